// File: doc/BRIEF.md
# Receiver Calibration Scheduler and Health Monitor

This block watches a set of health indicators from a wideband receiver. It decides when the channels must be recalibrated and how far the confidence of the direction-finding output must be lowered. The inputs are single-cycle overdrive and gain-clamp event pulses, a temperature code, a baseline noise metric, and a calibration-complete strobe. The strobe arrives together with the phase, delay and gain residuals measured by that calibration.

A request for calibration is raised by events rather than by a timer. The events are a move into another temperature band (with hysteresis on each edge), a burst of stress activity inside a sliding window, and a calibration whose residuals overrun their limits. Requests that arrive while a calibration is outstanding are merged into one pending request. That request is issued once the outstanding calibration completes. The block also reports the age of the last calibration, a coherency-valid flag and a two-bit confidence level. It keeps saturating stress counters and a noise peak tracker for trending.

Top module: `rx_cal_health`

## Requirements
- R1: While reset is held and at the first cycle after it, `ovd_count`, `clamp_count` and `noise_peak` are 0, `cal_age` is all ones, and `coh_valid` and `df_conf` are 0. A request is pending from reset, so `cal_req` is 1 for the cycle after the first clock edge following reset release.
- R2: Each sampled `ovd_evt` adds one to `ovd_count`, and each sampled `clamp_evt` adds one to `clamp_count`. Both counters stop at 255 and never wrap.
- R3: `cal_age` reads 0 in the cycle after a sampled `cal_done`. It then grows by one per clock and stops at all ones.
- R4: The temperature band is `temp_code >> 4` (16 codes per band). The band only changes when the reading reaches the current band's upper edge plus 2, or falls more than 2 codes below its lower edge. Each change raises a calibration trigger.
- R5: The stress sum is the number of overdrive plus clamp events sampled over the last `win_len` clock edges. The sum covers at most 64 edges and does not count the current edge. When the sum goes from below `stress_limit` to at or above it, a trigger is raised. A limit of 0 disables this trigger.
- R6: At a sampled `cal_done`, if any residual is larger than its limit, `coh_valid` goes to 0 and a trigger is raised. Otherwise `coh_valid` goes to 1.
- R7: At `cal_done`, each residual r is graded against its limit L. The grade is 0 if r > L, 1 if 2r > L, 2 if 4r > L, and 3 otherwise. The residual level is the lowest of the three grades and is held until the next `cal_done`.
- R8: The age level is 3 below an age of 200, 2 below 400, 1 below 800, and 0 from then on. `df_conf` is the lower of the residual level and the age level, with 3 meaning best.
- R9: A trigger sampled at clock edge t makes `cal_req` high for exactly one cycle after edge t+1, provided no calibration is outstanding. From a request until the next `cal_done`, no further request is issued. Triggers that arrive meanwhile are merged, and the merged request is issued one edge after the `cal_done` edge.
- R10: `noise_peak` restarts from the `noise_lvl` sampled with `cal_done`. Otherwise it holds the largest `noise_lvl` seen since then.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ovd_evt | input | 1 | Overdrive event pulse |
| clamp_evt | input | 1 | Gain-clamp event pulse |
| temp_code | input | 8 | Temperature reading |
| noise_lvl | input | 12 | Baseline noise metric |
| cal_done | input | 1 | Calibration-complete strobe |
| phase_res | input | 10 | Phase residual, valid with cal_done |
| delay_res | input | 10 | Delay residual, valid with cal_done |
| gain_res | input | 10 | Gain residual, valid with cal_done |
| phase_lim | input | 10 | Phase residual limit |
| delay_lim | input | 10 | Delay residual limit |
| gain_lim | input | 10 | Gain residual limit |
| win_len | input | 7 | Stress window length in cycles |
| stress_limit | input | 8 | Stress event count limit, 0 disables |
| cal_req | output | 1 | Calibration request pulse |
| cal_age | output | 16 | Cycles since last calibration, saturating |
| coh_valid | output | 1 | Residuals within limits at last calibration |
| df_conf | output | 2 | Confidence level, 3 best |
| ovd_count | output | 8 | Saturating overdrive counter |
| clamp_count | output | 8 | Saturating clamp counter |
| noise_peak | output | 12 | Noise peak since last calibration |

## Verification
The counters, age, coherency flag, residual level and noise peak all change on the clock edge that samples their input, so they are due one cycle after the stimulus. `df_conf` follows those registers with no added delay. A request is due two edges after its trigger: a band move, a stress crossing one edge after the events that cause it, or an overrun at `cal_done`. The bench drives inputs on the falling edge and updates a cycle model on the rising edge. It compares every output at the next falling edge, so each result is checked in exactly the cycle it is due. The directed cases wait the same counted number of edges before sampling.

// File: rtl/rxh_pkg.sv
// Shared definitions for the calibration scheduler and health monitor.
// Assumes confidence levels are ordered so that a larger value is better.
package rxh_pkg;
    localparam int NUM_RES = 3;           // phase, delay, gain residuals
    typedef logic [1:0] conf_t;           // 0 = no confidence, 3 = full

    // Lower of two confidence levels.
    function automatic conf_t lvl_min(input conf_t a, input conf_t b);
        return (a < b) ? a : b;
    endfunction
endpackage

// File: rtl/rxh_sat_cnt.sv
// Saturating up-counter with synchronous clear.
// Assumes: clr has priority over inc; RST_FULL selects the reset value
// (all ones when set, zero otherwise).
module rxh_sat_cnt #(
    parameter int W        = 8,
    parameter bit RST_FULL = 1'b0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         inc,
    output logic [W-1:0] count
);
    // Count up, hold at the maximum, clear on request.
    always_ff @(posedge clk) begin
        if (!rst_n)
            count <= RST_FULL ? '1 : '0;
        else if (clr)
            count <= '0;
        else if (inc && (count != '1))
            count <= count + 1'b1;
    end
endmodule

// File: rtl/rxh_temp_band.sv
// Temperature banding with hysteresis on both edges.
// Band index is temp >> SHIFT. A move is flagged combinationally while the
// reading lies HYST codes beyond the stored band; the band register follows
// on the same edge. Assumes the reading is stable during reset.
module rxh_temp_band #(
    parameter int TW    = 8,
    parameter int SHIFT = 4,
    parameter int HYST  = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [TW-1:0] temp,
    output logic          band_move
);
    localparam int EW = TW + 2;           // headroom for edge arithmetic
    localparam int BW = TW - SHIFT;

    logic [BW-1:0] band_q;
    logic [EW-1:0] lo_edge, hi_edge, t_ext;

    // Edges of the current band, widened against overflow.
    always_comb begin
        lo_edge   = EW'({band_q, {SHIFT{1'b0}}});
        hi_edge   = lo_edge + EW'(1 << SHIFT) + EW'(HYST);
        t_ext     = EW'(temp);
        band_move = (t_ext >= hi_edge) || ((t_ext + EW'(HYST)) < lo_edge);
    end

    // Load the band at reset and whenever the reading leaves it.
    always_ff @(posedge clk) begin
        if (!rst_n || band_move)
            band_q <= temp[TW-1:SHIFT];
    end
endmodule

// File: rtl/rxh_stress_win.sv
// Sliding-window stress detector.
// Keeps the per-cycle event count (0..2) of the last MAX_WIN edges and sums
// the newest win_len entries. Flags the rising crossing of the limit.
// Assumes MAX_WIN >= 2; a limit of zero disables detection.
module rxh_stress_win #(
    parameter int MAX_WIN = 64,
    parameter int WL_W    = 7,
    parameter int SUM_W   = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ovd,
    input  logic             clamp,
    input  logic [WL_W-1:0]  win_len,
    input  logic [SUM_W-1:0] limit,
    output logic             rise
);
    logic [MAX_WIN-1:0][1:0] hist;
    logic [1:0]              evt;
    logic [SUM_W-1:0]        sum;
    logic                    over_now, over_q;

    assign evt = {1'b0, ovd} + {1'b0, clamp};

    // Shift the newest per-cycle event count into the history.
    always_ff @(posedge clk) begin
        if (!rst_n)
            hist <= '0;
        else
            hist <= {hist[MAX_WIN-2:0], evt};
    end

    // Sum the entries that lie inside the programmed window.
    always_comb begin
        sum = '0;
        for (int i = 0; i < MAX_WIN; i++) begin
            if (WL_W'(i) < win_len)
                sum = sum + SUM_W'(hist[i]);
        end
        over_now = (limit != '0) && (sum >= limit);
    end

    // Remember the last comparison to find the rising crossing.
    always_ff @(posedge clk) begin
        if (!rst_n)
            over_q <= 1'b0;
        else
            over_q <= over_now;
    end

    assign rise = over_now && !over_q;
endmodule

// File: rtl/rxh_resid_eval.sv
// Grades each residual against its limit and reduces to one level.
// Grade: 0 above the limit, 1 above half, 2 above a quarter, else 3.
// Purely combinational; the caller registers the result.
module rxh_resid_eval
    import rxh_pkg::*;
#(
    parameter int RW = 10
) (
    input  logic [NUM_RES-1:0][RW-1:0] res,
    input  logic [NUM_RES-1:0][RW-1:0] lim,
    output conf_t                      lvl,
    output logic                       any_over
);
    conf_t [NUM_RES-1:0] grade;
    logic  [NUM_RES-1:0] over;

    for (genvar g = 0; g < NUM_RES; g++) begin : g_ch
        logic [RW+1:0] r1, r2, r4, lx;
        assign lx = {2'b00, lim[g]};
        assign r1 = {2'b00, res[g]};
        assign r2 = {1'b0, res[g], 1'b0};
        assign r4 = {res[g], 2'b00};
        assign over[g] = r1 > lx;

        // Grade one residual by comparing scaled copies with the limit.
        always_comb begin
            if (over[g])      grade[g] = 2'd0;
            else if (r2 > lx) grade[g] = 2'd1;
            else if (r4 > lx) grade[g] = 2'd2;
            else              grade[g] = 2'd3;
        end
    end

    // Take the worst grade across all residuals.
    always_comb begin
        lvl = grade[0];
        for (int k = 1; k < NUM_RES; k++)
            lvl = lvl_min(lvl, grade[k]);
        any_over = |over;
    end
endmodule

// File: rtl/rx_cal_health.sv
// Calibration scheduler and health monitor (top).
// Merges band-move, stress and residual-overrun triggers into one pending
// request, issues it as a one-cycle pulse while no calibration is
// outstanding, tracks calibration age and derives the confidence level.
// Assumes cal_done marks the end of the outstanding calibration and that
// the residual inputs are valid in the same cycle.
module rx_cal_health
    import rxh_pkg::*;
#(
    parameter int TEMP_W     = 8,
    parameter int BAND_SHIFT = 4,
    parameter int BAND_HYST  = 2,
    parameter int CNT_W      = 8,
    parameter int AGE_W      = 16,
    parameter int AGE_FRESH  = 200,
    parameter int AGE_MID    = 400,
    parameter int AGE_OLD    = 800,
    parameter int RES_W      = 10,
    parameter int NOISE_W    = 12,
    parameter int MAX_WIN    = 64,
    localparam int WL_W      = $clog2(MAX_WIN + 1),
    localparam int SUM_W     = $clog2(2 * MAX_WIN + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               ovd_evt,
    input  logic               clamp_evt,
    input  logic [TEMP_W-1:0]  temp_code,
    input  logic [NOISE_W-1:0] noise_lvl,
    input  logic               cal_done,
    input  logic [RES_W-1:0]   phase_res,
    input  logic [RES_W-1:0]   delay_res,
    input  logic [RES_W-1:0]   gain_res,
    input  logic [RES_W-1:0]   phase_lim,
    input  logic [RES_W-1:0]   delay_lim,
    input  logic [RES_W-1:0]   gain_lim,
    input  logic [WL_W-1:0]    win_len,
    input  logic [SUM_W-1:0]   stress_limit,
    output logic               cal_req,
    output logic [AGE_W-1:0]   cal_age,
    output logic               coh_valid,
    output logic [1:0]         df_conf,
    output logic [CNT_W-1:0]   ovd_count,
    output logic [CNT_W-1:0]   clamp_count,
    output logic [NOISE_W-1:0] noise_peak
);
    localparam logic [AGE_W-1:0] AGE_T3 = AGE_W'(AGE_FRESH);
    localparam logic [AGE_W-1:0] AGE_T2 = AGE_W'(AGE_MID);
    localparam logic [AGE_W-1:0] AGE_T1 = AGE_W'(AGE_OLD);

    logic  band_move, stress_rise, res_any_over, trig, issue;
    conf_t res_lvl_now, reslvl_q, age_lvl;
    logic  coh_q, pend_q, busy_q, req_q;
    logic  [NOISE_W-1:0] noise_q;
    logic  [1:0] evt_vec;
    logic  [1:0][CNT_W-1:0] evt_cnt;

    rxh_temp_band #(
        .TW(TEMP_W), .SHIFT(BAND_SHIFT), .HYST(BAND_HYST)
    ) u_band (
        .clk(clk), .rst_n(rst_n), .temp(temp_code), .band_move(band_move)
    );

    rxh_stress_win #(
        .MAX_WIN(MAX_WIN), .WL_W(WL_W), .SUM_W(SUM_W)
    ) u_stress (
        .clk(clk), .rst_n(rst_n), .ovd(ovd_evt), .clamp(clamp_evt),
        .win_len(win_len), .limit(stress_limit), .rise(stress_rise)
    );

    rxh_resid_eval #(.RW(RES_W)) u_resid (
        .res({gain_res, delay_res, phase_res}),
        .lim({gain_lim, delay_lim, phase_lim}),
        .lvl(res_lvl_now),
        .any_over(res_any_over)
    );

    // One saturating trend counter per stress source.
    assign evt_vec = {clamp_evt, ovd_evt};
    for (genvar g = 0; g < 2; g++) begin : g_evt
        rxh_sat_cnt #(.W(CNT_W), .RST_FULL(1'b0)) u_cnt (
            .clk(clk), .rst_n(rst_n), .clr(1'b0),
            .inc(evt_vec[g]), .count(evt_cnt[g])
        );
    end
    assign ovd_count   = evt_cnt[0];
    assign clamp_count = evt_cnt[1];

    rxh_sat_cnt #(.W(AGE_W), .RST_FULL(1'b1)) u_age (
        .clk(clk), .rst_n(rst_n), .clr(cal_done), .inc(1'b1), .count(cal_age)
    );

    assign trig  = band_move | stress_rise | (cal_done & res_any_over);
    assign issue = pend_q & ~busy_q;

    // Request scheduling: merge triggers, issue when idle, hold while busy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= 1'b1;
            busy_q <= 1'b0;
            req_q  <= 1'b0;
        end else begin
            req_q  <= issue;
            busy_q <= issue ? 1'b1 : (cal_done ? 1'b0 : busy_q);
            pend_q <= (pend_q & ~issue) | trig;
        end
    end

    // Capture residual quality at each calibration completion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            reslvl_q <= 2'd0;
            coh_q    <= 1'b0;
        end else if (cal_done) begin
            reslvl_q <= res_lvl_now;
            coh_q    <= ~res_any_over;
        end
    end

    // Track the noise peak since the last calibration.
    always_ff @(posedge clk) begin
        if (!rst_n)
            noise_q <= '0;
        else if (cal_done || (noise_lvl > noise_q))
            noise_q <= noise_lvl;
    end

    // Map calibration age onto a confidence ceiling.
    always_comb begin
        if (cal_age < AGE_T3)      age_lvl = 2'd3;
        else if (cal_age < AGE_T2) age_lvl = 2'd2;
        else if (cal_age < AGE_T1) age_lvl = 2'd1;
        else                       age_lvl = 2'd0;
    end

    assign df_conf    = lvl_min(reslvl_q, age_lvl);
    assign coh_valid  = coh_q;
    assign cal_req    = req_q;
    assign noise_peak = noise_q;
endmodule

// File: rtl/rx_cal_health_chk.sv
// Property checker for rx_cal_health, attached with bind.
// Observes ports plus the internal outstanding-calibration flag.
module rx_cal_health_chk #(
    parameter int CNT_W   = 8,
    parameter int AGE_W   = 16,
    parameter int AGE_OLD = 800
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cal_req,
    input logic             cal_done,
    input logic             busy_q,
    input logic             ovd_evt,
    input logic             clamp_evt,
    input logic [CNT_W-1:0] ovd_count,
    input logic [CNT_W-1:0] clamp_count,
    input logic [AGE_W-1:0] cal_age,
    input logic             coh_valid,
    input logic [1:0]       df_conf
);
    AST_REQ_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        cal_req |=> !cal_req);                                          // R9
    AST_NO_REQ_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        busy_q |=> !cal_req);                                           // R9
    AST_AGE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        cal_done |=> (cal_age == '0));                                  // R3
    AST_AGE_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        ((cal_age == '1) && !cal_done) |=> (cal_age == '1));            // R3
    AST_OVD_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (ovd_evt && (ovd_count != '1)) |=> (ovd_count == $past(ovd_count) + 1'b1)); // R2
    AST_OVD_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (ovd_count == '1) |=> (ovd_count == '1));                       // R2
    AST_CLAMP_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (clamp_count == '1) |=> (clamp_count == '1));                   // R2
    AST_INCOHERENT_ZERO_CONF: assert property (@(posedge clk) disable iff (!rst_n)
        !coh_valid |-> (df_conf == 2'd0));                              // R6
    AST_OLD_CAL_ZERO_CONF: assert property (@(posedge clk) disable iff (!rst_n)
        (cal_age >= AGE_W'(AGE_OLD)) |-> (df_conf == 2'd0));            // R8
endmodule

bind rx_cal_health rx_cal_health_chk #(
    .CNT_W(CNT_W), .AGE_W(AGE_W), .AGE_OLD(AGE_OLD)
) u_chk (
    .clk(clk), .rst_n(rst_n), .cal_req(cal_req), .cal_done(cal_done),
    .busy_q(busy_q), .ovd_evt(ovd_evt), .clamp_evt(clamp_evt),
    .ovd_count(ovd_count), .clamp_count(clamp_count), .cal_age(cal_age),
    .coh_valid(coh_valid), .df_conf(df_conf)
);

// File: tb/test_rx_cal_health.sv
// Bench: cycle model updated on the rising edge, all outputs compared on the
// falling edge, directed corner cases plus seeded random stimulus.
module test_rx_cal_health;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ovd_evt = 1'b0, clamp_evt = 1'b0, cal_done = 1'b0;
    logic [7:0]  temp_code = 8'd40;
    logic [11:0] noise_lvl = '0;
    logic [9:0]  phase_res = '0, delay_res = '0, gain_res = '0;
    logic [9:0]  phase_lim = 10'd100, delay_lim = 10'd100, gain_lim = 10'd100;
    logic [6:0]  win_len = 7'd8;
    logic [7:0]  stress_limit = 8'd6;
    logic        cal_req, coh_valid;
    logic [15:0] cal_age;
    logic [1:0]  df_conf;
    logic [7:0]  ovd_count, clamp_count;
    logic [11:0] noise_peak;

    rx_cal_health i_rx_cal_health (
        .clk(clk), .rst_n(rst_n), .ovd_evt(ovd_evt), .clamp_evt(clamp_evt),
        .temp_code(temp_code), .noise_lvl(noise_lvl), .cal_done(cal_done),
        .phase_res(phase_res), .delay_res(delay_res), .gain_res(gain_res),
        .phase_lim(phase_lim), .delay_lim(delay_lim), .gain_lim(gain_lim),
        .win_len(win_len), .stress_limit(stress_limit), .cal_req(cal_req),
        .cal_age(cal_age), .coh_valid(coh_valid), .df_conf(df_conf),
        .ovd_count(ovd_count), .clamp_count(clamp_count), .noise_peak(noise_peak)
    );

    always #5 clk = ~clk;   // 100 MHz

    int checks = 0, failures = 0, cyc = 0;
    bit cmp_en = 1'b0, done = 1'b0;

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d at cycle %0d", tag, act, exp, cyc);
        end
    endtask

    task automatic report();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    // ---------------- reference model (from the requirements) -------------
    int m_ovd, m_clamp, m_age, m_band, m_reslvl, m_noise;
    bit m_pend, m_busy, m_req, m_coh, m_over_q;
    int m_hist[64];
    int wl, ssum, g1, g2, g3, lo;
    bit over_now, trig, bad, issue;

    function automatic int grade(input int r, input int l);
        if (r > l) return 0;
        if (2 * r > l) return 1;
        if (4 * r > l) return 2;
        return 3;
    endfunction

    function automatic int age_level(input int a);
        if (a < 200) return 3;
        if (a < 400) return 2;
        if (a < 800) return 1;
        return 0;
    endfunction

    function automatic int imin(input int a, input int b);
        return (a < b) ? a : b;
    endfunction

    always @(posedge clk) begin
        cyc++;
        if (!rst_n) begin
            m_ovd = 0; m_clamp = 0; m_age = 65535; m_band = temp_code / 16;
            m_reslvl = 0; m_noise = 0; m_pend = 1; m_busy = 0; m_req = 0;
            m_coh = 0; m_over_q = 0;
            for (int i = 0; i < 64; i++) m_hist[i] = 0;
        end else begin
            wl = (win_len > 64) ? 64 : win_len;
            ssum = 0;
            for (int i = 0; i < wl; i++) ssum += m_hist[i];
            over_now = (stress_limit != 0) && (ssum >= stress_limit);
            trig = 0;
            lo = m_band * 16;
            if ((temp_code >= lo + 18) || (temp_code + 2 < lo)) begin
                m_band = temp_code / 16;
                trig = 1;
            end
            if (over_now && !m_over_q) trig = 1;
            m_over_q = over_now;
            issue = m_pend && !m_busy;
            if (cal_done) begin
                g1 = grade(phase_res, phase_lim);
                g2 = grade(delay_res, delay_lim);
                g3 = grade(gain_res, gain_lim);
                bad = (phase_res > phase_lim) || (delay_res > delay_lim) || (gain_res > gain_lim);
                if (bad) trig = 1;
                m_coh = !bad;
                m_reslvl = imin(g1, imin(g2, g3));
                m_age = 0;
                m_noise = noise_lvl;
            end else begin
                if (m_age < 65535) m_age++;
                if (noise_lvl > m_noise) m_noise = noise_lvl;
            end
            m_req = issue;
            m_busy = issue ? 1'b1 : (cal_done ? 1'b0 : m_busy);
            m_pend = (m_pend && !issue) || trig;
            for (int i = 63; i > 0; i--) m_hist[i] = m_hist[i-1];
            m_hist[0] = ovd_evt + clamp_evt;
            if (ovd_evt && m_ovd < 255) m_ovd++;
            if (clamp_evt && m_clamp < 255) m_clamp++;
        end
    end

    // Per-cycle comparison of every output, away from the active edge.
    always @(negedge clk) begin
        if (cmp_en && rst_n) begin
            chk("R9 cal_req", cal_req, m_req);
            chk("R3 cal_age", cal_age, m_age);
            chk("R6 coh_valid", coh_valid, m_coh);
            chk("R8 df_conf", df_conf, imin(m_reslvl, age_level(m_age)));
            chk("R2 ovd_count", ovd_count, m_ovd);
            chk("R2 clamp_count", clamp_count, m_clamp);
            chk("R10 noise_peak", noise_peak, m_noise);
        end
    end

    // Watchdog: an expired run counts as a failure.
    always @(posedge clk) begin
        if (cyc > 150000) begin
            failures++;
            $display("FAIL watchdog expired at cycle %0d", cyc);
            report();
        end
    end

    task automatic tick(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic cal_pulse(input int p, input int d, input int g);
        phase_res = 10'(p); delay_res = 10'(d); gain_res = 10'(g);
        cal_done = 1'b1;
        tick(1);
        cal_done = 1'b0;
    endtask

    initial begin
        void'($urandom(32'h5eed_1234));
        tick(3);
        // R1: values during reset
        chk("R1 ovd_count reset", ovd_count, 0);
        chk("R1 clamp_count reset", clamp_count, 0);
        chk("R1 cal_age reset", cal_age, 65535);
        chk("R1 coh_valid reset", coh_valid, 0);
        chk("R1 df_conf reset", df_conf, 0);
        chk("R1 noise_peak reset", noise_peak, 0);
        chk("R1 cal_req reset", cal_req, 0);
        rst_n = 1'b1;
        cmp_en = 1'b1;
        tick(1);
        chk("R1 request after reset", cal_req, 1);
        tick(1);

        // R7/R6: residual grading at calibration completion
        cal_pulse(30, 10, 0);
        chk("R7 conf phase 30 of 100", df_conf, 2);
        chk("R6 coherent", coh_valid, 1);
        chk("R3 age zero after cal", cal_age, 0);
        cal_pulse(25, 0, 0);
        chk("R7 conf 25 of 100", df_conf, 3);
        cal_pulse(0, 50, 0);
        chk("R7 conf 50 of 100", df_conf, 2);
        cal_pulse(0, 0, 100);
        chk("R7 conf at limit", df_conf, 1);
        chk("R6 coherent at limit", coh_valid, 1);
        cal_pulse(0, 0, 101);
        chk("R6 incoherent over limit", coh_valid, 0);
        chk("R7 conf over limit", df_conf, 0);
        chk("R6 no request yet", cal_req, 0);
        tick(1);
        chk("R6 overrun request", cal_req, 1);
        tick(1);
        cal_pulse(0, 0, 0);
        tick(2);

        // R4: band hysteresis (band 2 covers 32..47)
        temp_code = 8'd49;
        tick(2);
        chk("R4 no move inside hysteresis", cal_req, 0);
        temp_code = 8'd50;
        tick(1);
        chk("R4 no request at trigger edge", cal_req, 0);
        tick(1);
        chk("R4 request on band move", cal_req, 1);
        tick(1);
        chk("R9 single-cycle request", cal_req, 0);
        temp_code = 8'd46;
        tick(2);
        temp_code = 8'd45;           // moves down while busy
        for (int i = 0; i < 3; i++) begin
            tick(1);
            chk("R9 suppressed while busy", cal_req, 0);
        end
        cal_pulse(0, 0, 0);
        chk("R9 not at done edge", cal_req, 0);
        tick(1);
        chk("R9 merged request after done", cal_req, 1);
        tick(1);
        cal_pulse(0, 0, 0);
        tick(12);

        // R5: stress window, 8 cycles, limit 6
        ovd_evt = 1'b1; clamp_evt = 1'b1;
        tick(3);
        ovd_evt = 1'b0; clamp_evt = 1'b0;
        tick(1);
        chk("R5 no request at crossing edge", cal_req, 0);
        tick(1);
        chk("R5 stress request", cal_req, 1);
        tick(1);
        cal_pulse(0, 0, 0);
        stress_limit = 8'd0;
        tick(10);
        ovd_evt = 1'b1; clamp_evt = 1'b1;
        tick(5);
        ovd_evt = 1'b0; clamp_evt = 1'b0;
        for (int i = 0; i < 4; i++) begin
            tick(1);
            chk("R5 limit zero disables", cal_req, 0);
        end
        tick(70);
        stress_limit = 8'd6;
        tick(2);

        // R10: noise peak tracking
        noise_lvl = 12'd5;
        cal_pulse(0, 0, 0);
        noise_lvl = 12'd900;
        tick(1);
        noise_lvl = 12'd3;
        tick(1);
        chk("R10 peak held", noise_peak, 900);
        cal_pulse(0, 0, 0);
        chk("R10 peak restarts", noise_peak, 3);
        noise_lvl = 12'd0;

        // R8: age-driven confidence decay (age 0 after the strobe)
        cal_pulse(0, 0, 0);
        for (int a = 1; a <= 800; a++) begin
            tick(1);
            if (a == 199) chk("R8 fresh level", df_conf, 3);
            if (a == 200) chk("R8 mid level", df_conf, 2);
            if (a == 400) chk("R8 old level", df_conf, 1);
            if (a == 800) chk("R8 expired level", df_conf, 0);
        end

        // R2: counter saturation
        ovd_evt = 1'b1; clamp_evt = 1'b1;
        tick(300);
        ovd_evt = 1'b0; clamp_evt = 1'b0;
        tick(1);
        chk("R2 ovd saturates", ovd_count, 255);
        chk("R2 clamp saturates", clamp_count, 255);

        // Seeded random mix checked by the cycle model
        for (int n = 0; n < 6000; n++) begin
            ovd_evt   = ($urandom_range(0, 7) == 0);
            clamp_evt = ($urandom_range(0, 9) == 0);
            noise_lvl = 12'($urandom_range(0, 4095));
            if ($urandom_range(0, 15) == 0) begin
                int t;
                t = int'(temp_code) + $urandom_range(0, 6) - 3;
                temp_code = 8'((t < 0) ? 0 : (t > 255 ? 255 : t));
            end
            if ($urandom_range(0, 200) == 0) win_len = 7'($urandom_range(0, 70));
            if ($urandom_range(0, 200) == 0) stress_limit = 8'($urandom_range(0, 10));
            cal_done = (m_busy && $urandom_range(0, 39) == 0) || ($urandom_range(0, 399) == 0);
            phase_res = 10'($urandom_range(0, 120));
            delay_res = 10'($urandom_range(0, 110));
            gain_res  = 10'($urandom_range(0, 105));
            tick(1);
        end
        cal_done = 1'b0; ovd_evt = 1'b0; clamp_evt = 1'b0;
        tick(2);
        report();
    end
endmodule